// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the purely combinational arithmetic and logic unit for a compact two-operand core. Each evaluation takes two operands, the four incoming condition flags (negative, zero, carry, overflow) and a five-bit operation code. It returns a result word, the next value of each flag, and a write-enable that tells the surrounding pipeline whether the result should be written to the destination register.

It covers addition and subtraction with and without the incoming carry, negation, five bitwise forms, a low-half multiply, four shifts and rotates whose amount comes from a register, and three flag-only forms (compare, compare-negative, test). Register storage, instruction decode and the flag register itself live outside the block. The caller feeds the flags back in and keeps the flag outputs for the next operation.

Top module: `flag_alu`

## Requirements
- R1: Op 0 gives A+B and op 1 gives A+B+Cin. C is the carry out of the top bit and V is set when the signed sum overflows.
- R2: Op 2 gives A−B and op 3 gives A−B−(1−Cin). C is set when no borrow occurs, that is when A ≥ B plus the borrow, unsigned. V marks signed overflow.
- R3: Op 4 gives 0−B with flags as for a subtraction from zero. C is set only when B is zero, and V is set only for B = 0x80000000.
- R4: Op 5 sets flags as op 2 would and op 6 sets flags as op 0 would. Both drive write-enable low.
- R5: Ops 7 to 11 give A AND B, A OR B, A XOR B, A AND NOT B and NOT B. C and V keep their incoming values.
- R6: Op 12 sets N and Z from A AND B, keeps C and V, and drives write-enable low.
- R7: Op 13 gives the low 32 bits of A×B. C and V keep their incoming values.
- R8: Shifts (ops 14 to 17) use only B[7:0] as the amount. An amount of 0 returns A unchanged and keeps C.
- R9: Op 14 is logical left and op 15 is logical right, both zero-filling, with C the last bit shifted out. An amount of exactly 32 gives 0 with C = A[0] (left) or A[31] (right). Amounts above 32 give 0 with C = 0.
- R10: Op 16 is arithmetic right, copying the sign bit in, with C the last bit out. Amounts of 32 or more give 32 copies of A[31] and C = A[31].
- R11: Op 17 rotates right by the amount mod 32, with C = result[31]. A non-zero multiple of 32 returns A with C = A[31].
- R12: For every op from 0 to 17, N = result[31] and Z = (result == 0). Write-enable is high for every op in that range except 5, 6 and 12.
- R13: Op codes 18 to 31 are unused. They give result 0, pass all four incoming flags through and drive write-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand (destination value) |
| b_i | input | 32 | Second operand; low 8 bits give the shift amount |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| res_o | output | 32 | Result word |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| wr_en_o | output | 1 | Result is to be written back |

## Verification
The bench builds the block with its defaults: a 32-bit word and an 8-bit shift-amount field. With these values, shift amounts from 33 to 255 are reachable. This brings the saturating ends of the logical, arithmetic and rotate shifters into play, as well as rotates by 64 or 96 that land on a multiple of the word. A quarter of the random vectors use a small B, so the exact-32 and 1-to-31 boundaries come up often. The other vectors use a full-width B, which drives carry and overflow through both signs.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_NEG = 5'd4,  OP_CMP = 5'd5,  OP_CMN = 5'd6,  OP_AND = 5'd7,
        OP_ORR = 5'd8,  OP_EOR = 5'd9,  OP_BIC = 5'd10, OP_MVN = 5'd11,
        OP_TST = 5'd12, OP_MUL = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15,
        OP_ASR = 5'd16, OP_ROR = 5'd17
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_MUL
    } unit_cls_e;

    typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } carry_src_e;

    typedef enum logic [2:0] { LG_AND, LG_OR, LG_XOR, LG_BIC, LG_NOT } logic_fn_e;

    typedef enum logic [1:0] { SH_LSL, SH_LSR, SH_ASR, SH_ROR } shift_fn_e;

    typedef struct packed {
        unit_cls_e  cls;
        logic       write;
        logic       zero_a;
        logic       inv_b;
        carry_src_e cin;
        logic_fn_e  lfn;
        shift_fn_e  sfn;
    } decode_t;

    function automatic decode_t decode_op(input logic [OP_W-1:0] op);
        decode_t d;
        d = '0;
        d.cls   = CLS_NONE;
        d.cin   = CIN_ZERO;
        d.lfn   = LG_AND;
        d.sfn   = SH_LSL;
        d.write = 1'b1;
        case (op)
            OP_ADD: d.cls = CLS_ARITH;
            OP_ADC: begin d.cls = CLS_ARITH; d.cin = CIN_FLAG; end
            OP_SUB: begin d.cls = CLS_ARITH; d.inv_b = 1'b1; d.cin = CIN_ONE; end
            OP_SBC: begin d.cls = CLS_ARITH; d.inv_b = 1'b1; d.cin = CIN_FLAG; end
            OP_NEG: begin d.cls = CLS_ARITH; d.zero_a = 1'b1; d.inv_b = 1'b1; d.cin = CIN_ONE; end
            OP_CMP: begin d.cls = CLS_ARITH; d.inv_b = 1'b1; d.cin = CIN_ONE; d.write = 1'b0; end
            OP_CMN: begin d.cls = CLS_ARITH; d.write = 1'b0; end
            OP_AND: d.cls = CLS_LOGIC;
            OP_ORR: begin d.cls = CLS_LOGIC; d.lfn = LG_OR; end
            OP_EOR: begin d.cls = CLS_LOGIC; d.lfn = LG_XOR; end
            OP_BIC: begin d.cls = CLS_LOGIC; d.lfn = LG_BIC; end
            OP_MVN: begin d.cls = CLS_LOGIC; d.lfn = LG_NOT; end
            OP_TST: begin d.cls = CLS_LOGIC; d.write = 1'b0; end
            OP_MUL: d.cls = CLS_MUL;
            OP_LSL: d.cls = CLS_SHIFT;
            OP_LSR: begin d.cls = CLS_SHIFT; d.sfn = SH_LSR; end
            OP_ASR: begin d.cls = CLS_SHIFT; d.sfn = SH_ASR; end
            OP_ROR: begin d.cls = CLS_SHIFT; d.sfn = SH_ROR; end
            default: d.write = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  logic                    c_i,
    input  logic                    zero_a_i,
    input  logic                    inv_b_i,
    input  alu_pkg::carry_src_e     cin_sel_i,
    output logic [WIDTH-1:0]        sum_o,
    output logic                    c_o,
    output logic                    v_o
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic             ci;
    logic [WIDTH:0]   total;

    always_comb begin
        a_eff = zero_a_i ? '0 : a_i;
        b_eff = inv_b_i ? ~b_i : b_i;
        case (cin_sel_i)
            CIN_ZERO: ci = 1'b0;
            CIN_ONE:  ci = 1'b1;
            default:  ci = c_i;
        endcase
        total = {1'b0, a_eff} + {1'b0, b_eff} + {{WIDTH{1'b0}}, ci};
        sum_o = total[MSB:0];
        c_o   = total[WIDTH];
        v_o   = (a_eff[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_eff[MSB]);
    end

    always_comb begin
        if (!inv_b_i && !ci)
            AST_ADD_WRAP: assert (c_o == (sum_o < a_eff)) else $error("carry without wrap"); // R1
        if (inv_b_i && ci)
            AST_NO_BORROW: assert (c_o == (a_eff >= b_i)) else $error("borrow mismatch"); // R2
        if (zero_a_i && inv_b_i && ci)
            AST_NEG_CARRY: assert (c_o == (b_i == '0)) else $error("negate carry"); // R3
    end

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    input  alu_pkg::logic_fn_e   fn_i,
    output logic [WIDTH-1:0]     res_o
);
    import alu_pkg::*;

    always_comb begin
        case (fn_i)
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_BIC:  res_o = a_i & ~b_i;
            LG_NOT:  res_o = ~b_i;
            default: res_o = a_i & b_i;
        endcase
    end

    always_comb begin
        if (fn_i == LG_BIC)
            AST_BIC_DISJOINT: assert ((res_o & b_i) == '0) else $error("bit-clear left bits"); // R5
    end

endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0]     a_i,
    input  logic [AMT_W-1:0]     amt_i,
    input  logic                 c_i,
    input  alu_pkg::shift_fn_e   fn_i,
    output logic [WIDTH-1:0]     res_o,
    output logic                 c_o
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    int unsigned      n;
    int unsigned      r;
    logic [WIDTH-1:0] tmp;

    always_comb begin
        n     = int'(amt_i);
        r     = n % WIDTH;
        res_o = a_i;
        c_o   = c_i;
        tmp   = '0;
        if (n != 0) begin
            case (fn_i)
                SH_LSL: begin
                    if (n < WIDTH) begin
                        res_o = a_i << n;
                        tmp   = a_i << (n - 1);
                        c_o   = tmp[MSB];
                    end else begin
                        res_o = '0;
                        c_o   = (n == WIDTH) ? a_i[0] : 1'b0;
                    end
                end
                SH_LSR: begin
                    if (n < WIDTH) begin
                        res_o = a_i >> n;
                        tmp   = a_i >> (n - 1);
                        c_o   = tmp[0];
                    end else begin
                        res_o = '0;
                        c_o   = (n == WIDTH) ? a_i[MSB] : 1'b0;
                    end
                end
                SH_ASR: begin
                    if (n < WIDTH) begin
                        res_o = $signed(a_i) >>> n;
                        tmp   = a_i >> (n - 1);
                        c_o   = tmp[0];
                    end else begin
                        res_o = {WIDTH{a_i[MSB]}};
                        c_o   = a_i[MSB];
                    end
                end
                default: begin
                    if (r == 0) begin
                        res_o = a_i;
                        c_o   = a_i[MSB];
                    end else begin
                        res_o = (a_i >> r) | (a_i << (WIDTH - r));
                        c_o   = res_o[MSB];
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (amt_i == '0)
            AST_ZERO_AMOUNT: assert (res_o == a_i && c_o == c_i) else $error("zero shift moved data"); // R8
        if ((fn_i == SH_LSL || fn_i == SH_LSR) && n > WIDTH)
            AST_WIDE_LOGICAL: assert (res_o == '0 && !c_o) else $error("wide logical shift"); // R9
        if (fn_i == SH_ASR && n >= WIDTH)
            AST_ASR_SATURATE: assert ((res_o == '0 || res_o == '1) && c_o == res_o[0]) else $error("wide arithmetic shift"); // R10
    end

endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [alu_pkg::OP_W-1:0] op_i,
    input  logic [WIDTH-1:0]         a_i,
    input  logic [WIDTH-1:0]         b_i,
    input  logic                     n_i,
    input  logic                     z_i,
    input  logic                     c_i,
    input  logic                     v_i,
    output logic [WIDTH-1:0]         res_o,
    output logic                     n_o,
    output logic                     z_o,
    output logic                     c_o,
    output logic                     v_o,
    output logic                     wr_en_o
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    decode_t          dec;
    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    logic [WIDTH-1:0] mul_res;

    assign dec = decode_op(op_i);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i       (a_i),
        .b_i       (b_i),
        .c_i       (c_i),
        .zero_a_i  (dec.zero_a),
        .inv_b_i   (dec.inv_b),
        .cin_sel_i (dec.cin),
        .sum_o     (arith_res),
        .c_o       (arith_c),
        .v_o       (arith_v)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (a_i),
        .b_i   (b_i),
        .fn_i  (dec.lfn),
        .res_o (bit_res)
    );

    alu_shifter #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shifter (
        .a_i   (a_i),
        .amt_i (b_i[AMT_W-1:0]),
        .c_i   (c_i),
        .fn_i  (dec.sfn),
        .res_o (sh_res),
        .c_o   (sh_c)
    );

    assign mul_res = a_i * b_i;

    always_comb begin
        res_o   = '0;
        c_o     = c_i;
        v_o     = v_i;
        wr_en_o = dec.write;
        case (dec.cls)
            CLS_ARITH: begin res_o = arith_res; c_o = arith_c; v_o = arith_v; end
            CLS_LOGIC: res_o = bit_res;
            CLS_SHIFT: begin res_o = sh_res; c_o = sh_c; end
            CLS_MUL:   res_o = mul_res;
            default:   res_o = '0;
        endcase
        if (dec.cls == CLS_NONE) begin
            n_o = n_i;
            z_o = z_i;
        end else begin
            n_o = res_o[MSB];
            z_o = (res_o == '0);
        end
    end

    always_comb begin
        if (op_i == OP_CMP || op_i == OP_CMN)
            AST_COMPARE_NO_WRITE: assert (!wr_en_o) else $error("compare wrote back"); // R4
        if (op_i >= OP_AND && op_i <= OP_MVN)
            AST_LOGIC_KEEPS_CV: assert (c_o == c_i && v_o == v_i) else $error("logic op touched C/V"); // R5
        if (op_i == OP_TST)
            AST_TEST_NO_WRITE: assert (!wr_en_o && c_o == c_i) else $error("test wrote back"); // R6
        if (op_i == OP_MUL && b_i == WIDTH'(1))
            AST_MUL_IDENTITY: assert (res_o == a_i) else $error("multiply by one"); // R7
        if (op_i <= OP_ROR)
            AST_SIGN_FLAG: assert (n_o == res_o[MSB]) else $error("N not from result"); // R12
        if (op_i > OP_ROR)
            AST_UNUSED_INERT: assert (!wr_en_o && n_o == n_i && z_o == z_i && c_o == c_i && v_o == v_i) else $error("unused op acted"); // R13
    end

endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;

    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    typedef struct packed {
        logic [31:0] r;
        logic n, z, c, v, we;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op;
    logic [31:0] a, b;
    logic        ni, zi, ci, vi;
    logic [31:0] res;
    logic        no, zo, co, vo, we;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    flag_alu uut (
        .op_i(op), .a_i(a), .b_i(b),
        .n_i(ni), .z_i(zi), .c_i(ci), .v_i(vi),
        .res_o(res), .n_o(no), .z_o(zo), .c_o(co), .v_o(vo), .wr_en_o(we)
    );

    function automatic logic ovf(input longint s);
        return (s > SMAX) || (s < SMIN);
    endfunction

    function automatic exp_t model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                                   input logic fn, input logic fz, input logic fc, input logic fv);
        exp_t        e;
        logic [32:0] s;
        logic [31:0] xx;
        logic [63:0] t;
        logic        bor;
        longint      sv;
        int          n;
        int          r;
        e.r = '0; e.n = fn; e.z = fz; e.c = fc; e.v = fv; e.we = 1'b1;
        n = int'(y[7:0]);
        r = n % 32;
        case (o)
            5'd0, 5'd1, 5'd6: begin
                s = {1'b0, x} + {1'b0, y} + {32'b0, (o == 5'd1) & fc};
                sv = longint'($signed(x)) + longint'($signed(y)) + ((o == 5'd1 && fc) ? 64'sd1 : 64'sd0);
                e.r = s[31:0]; e.c = s[32]; e.v = ovf(sv);
                if (o == 5'd6) e.we = 1'b0;
            end
            5'd2, 5'd3, 5'd4, 5'd5: begin
                xx  = (o == 5'd4) ? 32'd0 : x;
                bor = (o == 5'd3) ? !fc : 1'b0;
                e.r = xx - y - {31'b0, bor};
                e.c = ({1'b0, xx} >= ({1'b0, y} + {32'b0, bor}));
                sv  = longint'($signed(xx)) - longint'($signed(y)) - (bor ? 64'sd1 : 64'sd0);
                e.v = ovf(sv);
                if (o == 5'd5) e.we = 1'b0;
            end
            5'd7:  e.r = x & y;
            5'd8:  e.r = x | y;
            5'd9:  e.r = x ^ y;
            5'd10: e.r = x & ~y;
            5'd11: e.r = ~y;
            5'd12: begin e.r = x & y; e.we = 1'b0; end
            5'd13: e.r = x * y;
            5'd14: begin
                e.r = x;
                if (n != 0) begin t = {32'b0, x} << n; e.r = t[31:0]; e.c = t[32]; end
            end
            5'd15: begin
                e.r = x;
                if (n != 0) begin t = {x, 32'b0} >> n; e.r = t[63:32]; e.c = t[31]; end
            end
            5'd16: begin
                e.r = x;
                if (n != 0) begin
                    t = $signed({x, 32'b0}) >>> ((n > 32) ? 32 : n);
                    e.r = t[63:32]; e.c = t[31];
                end
            end
            5'd17: begin
                e.r = x;
                if (n != 0) begin
                    t = {x, x} >> r;
                    e.r = t[31:0]; e.c = e.r[31];
                end
            end
            default: e.we = 1'b0;
        endcase
        if (o <= 5'd17) begin
            e.n = e.r[31];
            e.z = (e.r == 32'd0);
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1:        return "R1";
            5'd2, 5'd3:        return "R2";
            5'd4:              return "R3";
            5'd5, 5'd6:        return "R4";
            5'd7, 5'd8, 5'd9, 5'd10, 5'd11: return "R5";
            5'd12:             return "R6";
            5'd13:             return "R7";
            5'd14, 5'd15:      return "R9";
            5'd16:             return "R10";
            5'd17:             return "R11";
            default:           return "R13";
        endcase
    endfunction

    task automatic run_one(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                           input logic [3:0] fl, input string tag);
        exp_t  e;
        string t;
        @(posedge clk);
        op = o; a = x; b = y; {ni, zi, ci, vi} = fl;
        @(negedge clk);
        e = model(o, x, y, fl[3], fl[2], fl[1], fl[0]);
        t = (tag == "") ? tag_of(o) : tag;
        checks++;
        if (res !== e.r || {no, zo, co, vo} !== {e.n, e.z, e.c, e.v} || we !== e.we) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h: actual res=%h nzcv=%b we=%b, expected res=%h nzcv=%b we=%b",
                     t, o, x, y, res, {no, zo, co, vo}, we, e.r, {e.n, e.z, e.c, e.v}, e.we);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [4:0]  ro;
        logic [31:0] rb;
        op = '0; a = '0; b = '0; {ni, zi, ci, vi} = 4'b0;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        rst = 1'b0;

        // Quiet state: add of zeros, Z set, write-enable high
        run_one(5'd0, 32'd0, 32'd0, 4'b0000, "R12");
        // R1 carry, overflow, carry-in
        run_one(5'd0, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R1");
        run_one(5'd0, 32'h7FFF_FFFF, 32'd1, 4'b0000, "R1");
        run_one(5'd1, 32'hFFFF_FFFE, 32'd1, 4'b0010, "R1");
        // R2 subtract with and without borrow
        run_one(5'd3, 32'd5, 32'd5, 4'b0000, "R2");
        run_one(5'd3, 32'd5, 32'd5, 4'b0010, "R2");
        run_one(5'd2, 32'd3, 32'd5, 4'b0000, "R2");
        run_one(5'd2, 32'h8000_0000, 32'd1, 4'b0000, "R2");
        // R3 negate corner values
        run_one(5'd4, 32'h1234_5678, 32'd0, 4'b0000, "R3");
        run_one(5'd4, 32'd0, 32'h8000_0000, 4'b0000, "R3");
        // R4 compare forms
        run_one(5'd5, 32'd45, 32'd45, 4'b0000, "R4");
        run_one(5'd6, 32'hFFFF_FFFF, 32'd1, 4'b1000, "R4");
        // R5 / R6 / R7
        run_one(5'd10, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'b0011, "R5");
        run_one(5'd12, 32'hF0F0_0000, 32'h0F0F_FFFF, 4'b0011, "R6");
        run_one(5'd13, 32'h1234_5678, 32'd1, 4'b0011, "R7");
        run_one(5'd13, 32'h0001_0000, 32'h0001_0000, 4'b0001, "R7");
        // R8 zero amount, including upper bits of B ignored
        run_one(5'd14, 32'h8000_0001, 32'd0, 4'b0010, "R8");
        run_one(5'd15, 32'h8000_0001, 32'h0000_0100, 4'b0000, "R8");
        // R9 logical boundaries
        run_one(5'd14, 32'h0000_0001, 32'd32, 4'b0000, "R9");
        run_one(5'd15, 32'h8000_0000, 32'd32, 4'b0000, "R9");
        run_one(5'd14, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R9");
        run_one(5'd15, 32'hFFFF_FFFF, 32'hFFFF_FFC8, 4'b0010, "R9");
        // R10 arithmetic saturation
        run_one(5'd16, 32'h8000_0000, 32'd200, 4'b0000, "R10");
        run_one(5'd16, 32'h8000_0010, 32'd4, 4'b0000, "R10");
        // R11 rotate
        run_one(5'd17, 32'h8000_0001, 32'd64, 4'b0000, "R11");
        run_one(5'd17, 32'h0000_000F, 32'd4, 4'b0000, "R11");
        // R13 unused code
        run_one(5'd20, 32'hDEAD_BEEF, 32'd1, 4'b1010, "R13");

        for (int i = 0; i < 4000; i++) begin
            ro = 5'($urandom % 20);
            rb = ($urandom % 4 == 0) ? 32'($urandom % 70) : 32'($urandom);
            run_one(ro, 32'($urandom), rb, 4'($urandom), "");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule